// File: doc/BRIEF.md
# Remote Terminal Subaddress Message Indexer

This block sits behind the word decoder of a dual-redundant command/response serial-bus remote terminal. It takes a decoded command word, consults a table of illegalization bits kept in shared memory, and answers with an accept or reject pulse. For an accepted subaddress command it fetches a four-word descriptor for that subaddress and direction. While the message is on the bus, it shows the data pointer that the transfer logic must use. When the end-of-message result arrives, it appends a three-word status entry to a sequential list. Each entry records validity, the time tag, the word count and the data address it belongs to. The block then writes the updated index state back into the descriptor.

Each subaddress chooses between two modes. In indexed mode, successive messages go to consecutive buffers until a programmed count of up to 128 is used up. In the other mode, every message lands in one fixed buffer. An interrupt pulse can be requested for every access to a subaddress, when the index count reaches zero, or for both. Mode commands (subaddress 0 or 31) get only the legality check; carrying them out belongs elsewhere. All tables and buffers live in a 64K-word space reached through a simple single-cycle memory port. Read data returns on the cycle after the request.

Top module: `rt_sa_indexer`

## Requirements
- R1: A subaddress command (subaddress 1..30) is rejected when bit `sa[3:0]` of the word at `ILL_BASE + {1'b0, tx, sa[4]}` is set. It is accepted otherwise. A rejected command produces one `cmdReject` pulse and no memory write.
- R2: A mode command (subaddress 0 or 31) checks bit `code[3:0]` of the word at `ILL_BASE + {1'b1, tx, code[4]}`, where the code is the word-count field. It produces an accept or reject pulse and reads no descriptor.
- R3: After accepting a subaddress command, the block reads the descriptor at `DESC_BASE + 4*{tx, sa}`. Offset 0 is control, 1 is the remaining count, 2 is the data pointer and 3 is the status pointer. It then holds `msgActive` high with `msgDataPtr` equal to the descriptor data pointer until `eomValid`.
- R4: Each finished message writes three words at the status pointer. The first word has valid in bit 15, tx in bit 14, the subaddress in bits 12:8 and the reported word count in bits 5:0. The second word is the time tag sampled at end of message, and the third is the data pointer the message used. The descriptor status pointer then becomes the old value plus 3.
- R5: With control bit 0 (index enable) set, a valid message and a non-zero count, the count drops by one and the data pointer advances by the command word count (field 0 means 32).
- R6: When the count is already zero, neither the count nor the data pointer changes.
- R7: With index enable clear, the count and data pointer are written back unchanged.
- R8: A message ending with an error writes its status entry with bit 15 clear and leaves the count and data pointer unchanged.
- R9: `irqPulse` fires once, as the last step of a message, when a cause is present. `irqCause[0]` is set when control bit 1 (every access) is set. `irqCause[1]` is set when control bit 2 is set and this message brought the count from 1 to 0.
- R10: `cmdValid` while busy and `eomValid` outside `msgActive` are ignored.
- R11: After reset, `busy`, `memReq`, `msgActive`, `cmdAccept`, `cmdReject` and `irqPulse` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Decoded command strobe |
| cmdTx | input | 1 | 1 = transmit command |
| cmdSubaddr | input | 5 | Subaddress field |
| cmdWordCnt | input | 5 | Word count / mode code field |
| eomValid | input | 1 | End-of-message strobe |
| eomOk | input | 1 | Message completed without error |
| eomWords | input | 6 | Words actually transferred |
| timeTag | input | 16 | Free-running time tag |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Write enable for the request |
| memAddr | output | 16 | Word address |
| memWdata | output | 16 | Write data |
| memRdata | input | 16 | Read data, one cycle after request |
| busy | output | 1 | Block is processing a command |
| cmdAccept | output | 1 | Command legal pulse |
| cmdReject | output | 1 | Command illegal pulse |
| msgActive | output | 1 | Waiting for end of message, pointer valid |
| msgDataPtr | output | 16 | Data buffer address for current message |
| irqPulse | output | 1 | Interrupt pulse |
| irqCause | output | 2 | bit0 access, bit1 count reached |

## Verification
A wrong captured descriptor word shows up in the first status entry or write-back, about a dozen cycles after the command. A wrong data pointer shows on `msgDataPtr` even earlier, as soon as `msgActive` rises. A count register that decrements wrongly stays hidden until the write-back of the same message. It then spreads to every later message on that subaddress, so count-zero sequences are run back to back. A bad illegalization lookup appears two cycles after the command as the wrong pulse, or as descriptor reads that should not happen.

// File: rtl/rt_idx_pkg.sv
package rt_idx_pkg;
  typedef enum logic [3:0] {
    OP_NONE, OP_ILL, OP_D0, OP_D1, OP_D2, OP_D3,
    OP_S0, OP_S1, OP_S2, OP_U1, OP_U2, OP_U3
  } memOp_e;

  typedef struct packed {
    memOp_e     memOp;
    logic       memWe;
    logic       ldCmd;
    logic       capEn;
    logic [1:0] capSel;
    logic       ldEom;
    logic       irqFire;
  } ctlStrobe_t;
endpackage

// File: rtl/rt_idx_datapath.sv
module rt_idx_datapath
  import rt_idx_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int SA_W      = 5,
  parameter int ILL_BASE  = 16'h0100,
  parameter int DESC_BASE = 16'h0200
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        stb,
  input  logic              cmdTx,
  input  logic [SA_W-1:0]   cmdSubaddr,
  input  logic [SA_W-1:0]   cmdWordCnt,
  input  logic              eomOk,
  input  logic [SA_W:0]     eomWords,
  input  logic [15:0]       timeTag,
  input  logic [15:0]       memRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memWdata,
  output logic              illegalHit,
  output logic              modeCmd,
  output logic [ADDR_W-1:0] msgDataPtr,
  output logic              irqPulse,
  output logic [1:0]        irqCause
);
  localparam int SEL_W = SA_W + 3;

  logic              txR, okR;
  logic [SA_W-1:0]   saR, wcR;
  logic [SA_W:0]     wordsR;
  logic [15:0]       ttR, cntR;
  logic [2:0]        ctrlR;
  logic [ADDR_W-1:0] dptrR, sptrR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txR <= 1'b0; saR <= '0; wcR <= '0; okR <= 1'b0; wordsR <= '0; ttR <= '0;
      ctrlR <= '0; cntR <= '0; dptrR <= '0; sptrR <= '0;
    end else begin
      if (stb.ldCmd) begin
        txR <= cmdTx; saR <= cmdSubaddr; wcR <= cmdWordCnt;
      end
      if (stb.capEn) begin
        case (stb.capSel)
          2'd0: ctrlR <= memRdata[2:0];
          2'd1: cntR  <= memRdata;
          2'd2: dptrR <= memRdata[ADDR_W-1:0];
          default: sptrR <= memRdata[ADDR_W-1:0];
        endcase
      end
      if (stb.ldEom) begin
        okR <= eomOk; wordsR <= eomWords; ttR <= timeTag;
      end
    end
  end

  logic [SA_W-1:0]   tableIdx;
  logic [ADDR_W-1:0] illAddr, descAddr, newDptr;
  logic [SA_W:0]     wcEff;
  logic [15:0]       newCnt;
  logic              advance;

  assign modeCmd    = (saR == '0) || (saR == '1);
  assign tableIdx   = modeCmd ? wcR : saR;
  assign illAddr    = ADDR_W'(ILL_BASE) + ADDR_W'({modeCmd, txR, tableIdx[SA_W-1]});
  assign illegalHit = memRdata[tableIdx[3:0]];
  assign descAddr   = ADDR_W'(DESC_BASE) + ADDR_W'({txR, saR, 2'b00});
  assign wcEff      = (wcR == '0) ? (SA_W+1)'(32) : {1'b0, wcR};
  assign advance    = ctrlR[0] && okR && (cntR != '0);
  assign newCnt     = advance ? cntR - 16'd1 : cntR;
  assign newDptr    = advance ? dptrR + ADDR_W'(wcEff) : dptrR;
  assign msgDataPtr = dptrR;
  assign irqCause   = {ctrlR[2] && advance && (cntR == 16'd1), ctrlR[1]};
  assign irqPulse   = stb.irqFire && (irqCause != 2'b00);
  assign memReq     = (stb.memOp != OP_NONE);
  assign memWe      = stb.memWe;

  always_comb begin
    memAddr  = '0;
    memWdata = '0;
    case (stb.memOp)
      OP_ILL: memAddr = illAddr;
      OP_D0:  memAddr = descAddr;
      OP_D1:  memAddr = descAddr + ADDR_W'(1);
      OP_D2:  memAddr = descAddr + ADDR_W'(2);
      OP_D3:  memAddr = descAddr + ADDR_W'(3);
      OP_S0: begin
        memAddr  = sptrR;
        memWdata = {okR, txR, 1'b0, saR, 2'b00, wordsR};
      end
      OP_S1: begin memAddr = sptrR + ADDR_W'(1); memWdata = ttR; end
      OP_S2: begin memAddr = sptrR + ADDR_W'(2); memWdata = 16'(dptrR); end
      OP_U1: begin memAddr = descAddr + ADDR_W'(1); memWdata = newCnt; end
      OP_U2: begin memAddr = descAddr + ADDR_W'(2); memWdata = 16'(newDptr); end
      OP_U3: begin memAddr = descAddr + ADDR_W'(3); memWdata = 16'(sptrR + ADDR_W'(3)); end
      default: ;
    endcase
  end

  logic unusedSel;
  assign unusedSel = ^{SEL_W'(0)};
endmodule

// File: rtl/rt_idx_ctrl.sv
module rt_idx_ctrl
  import rt_idx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       eomValid,
  input  logic       illegalHit,
  input  logic       modeCmd,
  output ctlStrobe_t stb,
  output logic       busy,
  output logic       cmdAccept,
  output logic       cmdReject,
  output logic       msgActive
);
  typedef enum logic [3:0] {
    S_IDLE, S_ILLRD, S_ILLCHK, S_DRD0, S_DRD1, S_DRD2, S_DRD3, S_DCAP,
    S_WAIT, S_ST0, S_ST1, S_ST2, S_UP1, S_UP2, S_UP3
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    stb       = '0;
    nextState = state;
    cmdAccept = 1'b0;
    cmdReject = 1'b0;
    msgActive = 1'b0;
    busy      = (state != S_IDLE);
    case (state)
      S_IDLE:   if (cmdValid) begin stb.ldCmd = 1'b1; nextState = S_ILLRD; end
      S_ILLRD:  begin stb.memOp = OP_ILL; nextState = S_ILLCHK; end
      S_ILLCHK: begin
        if (illegalHit) begin cmdReject = 1'b1; nextState = S_IDLE; end
        else begin
          cmdAccept = 1'b1;
          nextState = modeCmd ? S_IDLE : S_DRD0;
        end
      end
      S_DRD0: begin stb.memOp = OP_D0; nextState = S_DRD1; end
      S_DRD1: begin stb.memOp = OP_D1; stb.capEn = 1'b1; stb.capSel = 2'd0; nextState = S_DRD2; end
      S_DRD2: begin stb.memOp = OP_D2; stb.capEn = 1'b1; stb.capSel = 2'd1; nextState = S_DRD3; end
      S_DRD3: begin stb.memOp = OP_D3; stb.capEn = 1'b1; stb.capSel = 2'd2; nextState = S_DCAP; end
      S_DCAP: begin stb.capEn = 1'b1; stb.capSel = 2'd3; nextState = S_WAIT; end
      S_WAIT: begin
        msgActive = 1'b1;
        if (eomValid) begin stb.ldEom = 1'b1; nextState = S_ST0; end
      end
      S_ST0: begin stb.memOp = OP_S0; stb.memWe = 1'b1; nextState = S_ST1; end
      S_ST1: begin stb.memOp = OP_S1; stb.memWe = 1'b1; nextState = S_ST2; end
      S_ST2: begin stb.memOp = OP_S2; stb.memWe = 1'b1; nextState = S_UP1; end
      S_UP1: begin stb.memOp = OP_U1; stb.memWe = 1'b1; nextState = S_UP2; end
      S_UP2: begin stb.memOp = OP_U2; stb.memWe = 1'b1; nextState = S_UP3; end
      S_UP3: begin
        stb.memOp = OP_U3; stb.memWe = 1'b1; stb.irqFire = 1'b1; nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end
endmodule

// File: rtl/rt_sa_indexer.sv
module rt_sa_indexer
  import rt_idx_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int SA_W      = 5,
  parameter int ILL_BASE  = 16'h0100,
  parameter int DESC_BASE = 16'h0200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdTx,
  input  logic [SA_W-1:0]   cmdSubaddr,
  input  logic [SA_W-1:0]   cmdWordCnt,
  input  logic              eomValid,
  input  logic              eomOk,
  input  logic [SA_W:0]     eomWords,
  input  logic [15:0]       timeTag,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memWdata,
  input  logic [15:0]       memRdata,
  output logic              busy,
  output logic              cmdAccept,
  output logic              cmdReject,
  output logic              msgActive,
  output logic [ADDR_W-1:0] msgDataPtr,
  output logic              irqPulse,
  output logic [1:0]        irqCause
);
  ctlStrobe_t stb;
  logic       illegalHit, modeCmd;

  rt_idx_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .eomValid(eomValid),
    .illegalHit(illegalHit), .modeCmd(modeCmd), .stb(stb), .busy(busy),
    .cmdAccept(cmdAccept), .cmdReject(cmdReject), .msgActive(msgActive)
  );

  rt_idx_datapath #(
    .ADDR_W(ADDR_W), .SA_W(SA_W), .ILL_BASE(ILL_BASE), .DESC_BASE(DESC_BASE)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdTx(cmdTx), .cmdSubaddr(cmdSubaddr),
    .cmdWordCnt(cmdWordCnt), .eomOk(eomOk), .eomWords(eomWords), .timeTag(timeTag),
    .memRdata(memRdata), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .illegalHit(illegalHit), .modeCmd(modeCmd),
    .msgDataPtr(msgDataPtr), .irqPulse(irqPulse), .irqCause(irqCause)
  );
endmodule

// File: rtl/rt_sa_indexer_chk.sv
module rt_sa_indexer_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memWe,
  input logic              busy,
  input logic              cmdAccept,
  input logic              cmdReject,
  input logic              msgActive,
  input logic              eomValid,
  input logic [ADDR_W-1:0] msgDataPtr,
  input logic              irqPulse
);
  // R1
  accept_reject_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdAccept && cmdReject));

  // R1
  reject_to_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdReject |=> !busy);

  // R3
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgActive && !eomValid) |=> (msgActive && $stable(msgDataPtr)));

  // R10
  no_write_in_msg_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgActive |-> !memWe);

  // R4
  write_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memReq);

  // R9
  irq_last_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !busy);
endmodule

bind rt_sa_indexer rt_sa_indexer_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memWe(memWe), .busy(busy),
  .cmdAccept(cmdAccept), .cmdReject(cmdReject), .msgActive(msgActive),
  .eomValid(eomValid), .msgDataPtr(msgDataPtr), .irqPulse(irqPulse)
);

// File: tb/rt_sa_indexer_tb_top.sv
module rt_sa_indexer_tb_top;
  localparam int ILL  = 16'h0100;
  localparam int DESC = 16'h0200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0, cmdTx = 1'b0;
  logic [4:0] cmdSubaddr = '0, cmdWordCnt = '0;
  logic eomValid = 1'b0, eomOk = 1'b0;
  logic [5:0] eomWords = '0;
  logic [15:0] timeTag = '0;
  logic memReq, memWe;
  logic [15:0] memAddr, memWdata;
  logic [15:0] memRdata = '0;
  logic busy, cmdAccept, cmdReject, msgActive, irqPulse;
  logic [15:0] msgDataPtr;
  logic [1:0] irqCause;

  always #10 clk = ~clk;

  rt_sa_indexer dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdTx(cmdTx),
    .cmdSubaddr(cmdSubaddr), .cmdWordCnt(cmdWordCnt), .eomValid(eomValid),
    .eomOk(eomOk), .eomWords(eomWords), .timeTag(timeTag), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .busy(busy), .cmdAccept(cmdAccept), .cmdReject(cmdReject),
    .msgActive(msgActive), .msgDataPtr(msgDataPtr), .irqPulse(irqPulse),
    .irqCause(irqCause)
  );

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  logic [15:0] mem [int];
  logic [31:0] expWr[$];
  string       expWrTag[$];
  logic [7:0]  expEv[$];
  string       expEvTag[$];

  function automatic logic [15:0] rd(int a);
    return mem.exists(a) ? mem[a] : 16'h0000;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model
  always @(posedge clk) begin
    if (memReq) begin
      if (memWe) mem[int'(memAddr)] = memWdata;
      else       memRdata <= rd(int'(memAddr));
    end
  end

  // monitor: compares DUT results against queued expectations
  always @(negedge clk) begin
    if (rstN) begin
      if (memReq && memWe) begin
        if (expWr.size() == 0) check(0, "R10 unexpected write", {memAddr, memWdata}, 32'h0);
        else begin
          logic [31:0] e; string t;
          e = expWr.pop_front(); t = expWrTag.pop_front();
          check({memAddr, memWdata} == e, t, {memAddr, memWdata}, e);
        end
      end
      if (cmdAccept || cmdReject || irqPulse) begin
        logic [7:0] a;
        a = cmdAccept ? 8'h10 : cmdReject ? 8'h20 : {6'b010000, irqCause};
        if (expEv.size() == 0) check(0, "R10 unexpected event", {24'h0, a}, 32'h0);
        else begin
          logic [7:0] e; string t;
          e = expEv.pop_front(); t = expEvTag.pop_front();
          check(a == e, t, {24'h0, a}, {24'h0, e});
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic pushWr(input int a, input logic [15:0] d, input string t);
    expWr.push_back({16'(a), d}); expWrTag.push_back(t);
  endtask

  task automatic pushEv(input logic [7:0] e, input string t);
    expEv.push_back(e); expEvTag.push_back(t);
  endtask

  task automatic setDesc(input bit tx, input int sa, input logic [15:0] c, input logic [15:0] n,
                         input logic [15:0] dp, input logic [15:0] sp);
    int b;
    b = DESC + 4 * ((int'(tx) << 5) | sa);
    mem[b] = c; mem[b+1] = n; mem[b+2] = dp; mem[b+3] = sp;
  endtask

  task automatic sendCmd(input bit tx, input int sa, input int wc);
    @(negedge clk);
    cmdValid = 1'b1; cmdTx = tx; cmdSubaddr = 5'(sa); cmdWordCnt = 5'(wc);
    @(negedge clk);
    cmdValid = 1'b0;
    while (busy && !msgActive) @(negedge clk);
  endtask

  task automatic runMsg(input bit tx, input int sa, input int wc, input bit ok,
                        input int words, input logic [15:0] tt, input string tag,
                        input bit pokeBusy);
    int b, wce;
    logic [15:0] c, n, dp, sp, nn, nd;
    logic adv;
    logic [1:0] cause;
    b  = DESC + 4 * ((int'(tx) << 5) | sa);
    c  = rd(b); n = rd(b+1); dp = rd(b+2); sp = rd(b+3);
    wce = (wc == 0) ? 32 : wc;
    adv = c[0] && ok && (n != 0);
    nn = adv ? n - 16'd1 : n;
    nd = adv ? dp + 16'(wce) : dp;
    cause = {c[2] && adv && (n == 16'd1), c[1]};
    pushEv(8'h10, "R1 accept");
    pushWr(int'(sp),   {ok, tx, 1'b0, 5'(sa), 2'b00, 6'(words)}, "R4 status word");
    pushWr(int'(sp)+1, tt, "R4 time tag");
    pushWr(int'(sp)+2, dp, "R4 cross reference");
    pushWr(b+1, nn, {tag, " count"});
    pushWr(b+2, nd, {tag, " data pointer"});
    pushWr(b+3, sp + 16'd3, "R4 status pointer");
    if (cause != 2'b00) pushEv({6'b010000, cause}, "R9 interrupt");
    sendCmd(tx, sa, wc);
    check(msgActive === 1'b1, "R3 msgActive", {31'h0, msgActive}, 32'h1);
    check(msgDataPtr === dp, "R3 msgDataPtr", {16'h0, msgDataPtr}, {16'h0, dp});
    if (pokeBusy) begin
      // R10: command strobe while busy must not start anything
      cmdValid = 1'b1; cmdSubaddr = 5'd2;
      @(negedge clk);
      cmdValid = 1'b0;
    end
    timeTag = tt; eomOk = ok; eomWords = 6'(words); eomValid = 1'b1;
    @(negedge clk);
    eomValid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  initial begin
    mem[ILL+0] = 16'h0080;      // rx sa7 illegal
    mem[ILL+5] = 16'h0008;      // mode rx, code 19 illegal
    repeat (3) @(negedge clk);
    // R11
    check(!busy && !memReq && !msgActive && !cmdAccept && !cmdReject && !irqPulse,
          "R11 reset outputs", {26'h0, busy, memReq, msgActive, cmdAccept, cmdReject, irqPulse}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: mode commands
    pushEv(8'h10, "R2 mode legal");
    sendCmd(1'b1, 0, 5);
    pushEv(8'h20, "R2 mode illegal");
    sendCmd(1'b0, 31, 19);
    check(!busy && expEv.size() == 0, "R2 no descriptor", {31'h0, busy}, 32'h0);

    // R1: illegal subaddress
    pushEv(8'h20, "R1 reject");
    sendCmd(1'b0, 7, 3);
    check(!busy, "R1 idle after reject", {31'h0, busy}, 32'h0);

    // R1 + R7: legal tx sa7, non-indexed
    setDesc(1'b1, 7, 16'h0000, 16'd4, 16'h1800, 16'h3800);
    runMsg(1'b1, 7, 3, 1'b1, 3, 16'hA001, "R7", 1'b0);

    // R5: indexed, two messages incl. word count 32
    setDesc(1'b0, 3, 16'h0001, 16'd5, 16'h1000, 16'h3000);
    runMsg(1'b0, 3, 4, 1'b1, 4, 16'h1234, "R5", 1'b0);
    runMsg(1'b0, 3, 0, 1'b1, 32, 16'h1240, "R5", 1'b0);

    // R8: error message
    runMsg(1'b0, 3, 2, 1'b0, 1, 16'h1300, "R8", 1'b0);

    // R6 + R9: count reaches zero, then stays
    setDesc(1'b0, 5, 16'h0005, 16'd1, 16'h2000, 16'h3100);
    runMsg(1'b0, 5, 6, 1'b1, 6, 16'h2222, "R6", 1'b0);
    runMsg(1'b0, 5, 6, 1'b1, 6, 16'h2223, "R6", 1'b0);

    // R9: access interrupt, also on an error message; R10 command while busy
    setDesc(1'b1, 12, 16'h0002, 16'd9, 16'h2400, 16'h3200);
    runMsg(1'b1, 12, 8, 1'b1, 8, 16'h4444, "R9", 1'b1);
    runMsg(1'b1, 12, 8, 1'b0, 2, 16'h4445, "R9", 1'b0);

    // R10: end-of-message strobe while idle
    eomOk = 1'b1; eomValid = 1'b1;
    @(negedge clk);
    eomValid = 1'b0;
    repeat (4) @(negedge clk);
    check(!busy && !memReq, "R10 eom ignored", {30'h0, busy, memReq}, 32'h0);

    repeat (3) @(negedge clk);
    check(expWr.size() == 0 && expEv.size() == 0, "R4 all results seen",
          expWr.size() + expEv.size(), 32'h0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule